// File: doc/BRIEF.md
# Password-Gated Access Level Controller

This block decides how much of a register-mapped memory a host may touch. The host writes a 32-bit key, one byte at a time, into a write-only entry register that sits in table 00h. The block compares the full entry, after every byte write, with two stored passwords. The level-1 password is held in four protected bytes of table 03h and can be changed. The level-2 password is a build-time constant that the map cannot alter. The comparison yields one of three access levels. A level-2 match carries every level-1 right with it.

The block sits between the host's byte-wide register bus and the backing memory. For every access it classifies the table and address into a region. It gates the memory's read and write strobes with the rights of the current level. It replaces the read data with FFh wherever the host may not look. The key bytes of the entry never come back on a read. The level-1 password bytes are stored inside the block and can be read back at level 2 only.

After reset the entry holds all ones. That value takes part in the comparison like any other value. If the level-1 password were ever set to all ones, a host with no key would get level-1 rights.

Top module: `pwd_access_ctrl`

## Requirements
- R1: After reset the entry is FFFFFFFFh and the level-1 password is 00000000h. With the default level-2 password of 00000000h, access_level reads 00 (user).
- R2: Writes to table 00h, bytes 7Bh to 7Eh, always land in the entry. 7Bh is the most significant byte. The level follows the whole 32-bit entry from the cycle after each byte write, so a partly written key can give a different level on the way.
- R3: Reads of table 00h, bytes 7Bh to 7Eh, return FFh at every level and never assert mem_re.
- R4: An entry equal to the level-2 password gives access_level 10. This holds even when the entry also equals the level-1 password.
- R5: An entry equal to the level-1 password, and not to the level-2 password, gives access_level 01. Any other entry gives 00. Code 11 never appears.
- R6: The level changes only as a result of a write to the entry or to the level-1 password. Reads and all other writes leave it unchanged.
- R7: A write to table 03h, bytes D3h to D6h (D3h most significant), updates the level-1 password only at level 10. At a lower level the write is dropped. A new password value takes part in the comparison from the next cycle.
- R8: A read of a region the level does not allow returns FFh with mem_re low. A write to such a region leaves mem_we low.
- R9: Region rights use the index order 0 = table 00h monitor area, 1 = table 01h customer area, 2 = every other table, 3 = level-1 password bytes. rgn_rd_ok is 0001 at user, 0011 at level 1 and 1111 at level 2. rgn_wr_ok is 0000, 0011 and 1111 at those levels.
- R10: Setting the level-1 password to FFFFFFFFh and then holding an all-ones entry gives level 01.
- R11: At level 10, reads of the level-1 password bytes return the stored byte, most significant first, from the block itself with mem_re low. Below level 10 they return FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_table | input | 8 | Table number of the access |
| bus_addr | input | 8 | Byte address within the table |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Masked read data, combinational |
| mem_rdata | input | 8 | Read data from the backing memory, combinational |
| mem_we | output | 1 | Gated write strobe to the backing memory |
| mem_re | output | 1 | Gated read strobe to the backing memory |
| access_level | output | 2 | 00 user, 01 level 1, 10 level 2 |
| rgn_rd_ok | output | 4 | Read right per region |
| rgn_wr_ok | output | 4 | Write right per region |

## Verification
A wrong entry byte or a wrong byte-order decode shows on access_level in the cycle after the write that caused it. It also shows on the rights vectors in that cycle, and on FFh masking of customer or control reads. A dropped or misdirected level-1 password write shows only later. It appears when the matching key is entered and the level stays at user, or when the stored byte is read back at level 2. The bench therefore mixes random key fragments with full passwords and with read-backs, so that stale state is exposed within a few operations.

// File: rtl/pwd_pkg.sv
// Shared types and the rights table of the access controller.
// Assumes four regions whose bit positions are fixed by region_e.
package pwd_pkg;

    typedef enum logic [1:0] {
        LVL_USER = 2'b00,
        LVL_ONE  = 2'b01,
        LVL_TWO  = 2'b10
    } level_e;

    typedef enum logic [1:0] {
        RGN_MON  = 2'd0,
        RGN_CUST = 2'd1,
        RGN_CTRL = 2'd2,
        RGN_KEY  = 2'd3
    } region_e;

    localparam int NUM_RGN = 4;

    // Read rights per level, one bit per region.
    function automatic logic [NUM_RGN-1:0] rd_rights(level_e lvl);
        case (lvl)
            LVL_ONE: return 4'b0011;
            LVL_TWO: return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

    // Write rights per level, one bit per region.
    function automatic logic [NUM_RGN-1:0] wr_rights(level_e lvl);
        case (lvl)
            LVL_ONE: return 4'b0011;
            LVL_TWO: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/pwd_byte_reg.sv
// Multi-byte register written one byte at a time.
// Byte index 0 is the most significant byte of value.
// Assumes at most one byte is written per cycle.
module pwd_byte_reg #(
    parameter int                  PW_BYTES  = 4,
    parameter logic [PW_BYTES*8-1:0] RESET_VAL = '1,
    localparam int                 IDX_W     = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      idx,
    input  logic [7:0]            wdata,
    output logic [PW_BYTES*8-1:0] value
);

    // Load the reset value, or replace the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= RESET_VAL;
        end else if (wr_en) begin
            for (int i = 0; i < PW_BYTES; i++) begin
                if (idx == IDX_W'(i)) begin
                    value[(PW_BYTES-1-i)*8 +: 8] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/pwd_compare.sv
// Compares the entry with both passwords byte by byte and picks the level.
// A level-2 match wins over a level-1 match. Purely combinational.
module pwd_compare
    import pwd_pkg::*;
#(
    parameter int                    PW_BYTES    = 4,
    parameter logic [PW_BYTES*8-1:0] L2_PASSWORD = '0
) (
    input  logic [PW_BYTES*8-1:0] entry,
    input  logic [PW_BYTES*8-1:0] l1_pw,
    output level_e                level
);

    logic [PW_BYTES-1:0] hit_l1;
    logic [PW_BYTES-1:0] hit_l2;

    for (genvar g = 0; g < PW_BYTES; g++) begin : g_byte
        assign hit_l1[g] = (entry[g*8 +: 8] == l1_pw[g*8 +: 8]);
        assign hit_l2[g] = (entry[g*8 +: 8] == L2_PASSWORD[g*8 +: 8]);
    end

    // Priority choice: level 2, then level 1, else user.
    always_comb begin
        if (&hit_l2)      level = LVL_TWO;
        else if (&hit_l1) level = LVL_ONE;
        else              level = LVL_USER;
    end

endmodule

// File: rtl/pwd_region_decode.sv
// Classifies each access, gates the memory strobes and masks read data.
// Assumes the backing memory returns mem_rdata combinationally.
// Entry bytes and level-1 password bytes are never forwarded to memory.
module pwd_region_decode
    import pwd_pkg::*;
#(
    parameter int            TBL_W       = 8,
    parameter int            ADDR_W      = 8,
    parameter int            PW_BYTES    = 4,
    parameter logic [TBL_W-1:0]  ENTRY_TABLE = 8'h00,
    parameter logic [ADDR_W-1:0] ENTRY_BASE  = 8'h7B,
    parameter logic [TBL_W-1:0]  CUST_TABLE  = 8'h01,
    parameter logic [TBL_W-1:0]  KEY_TABLE   = 8'h03,
    parameter logic [ADDR_W-1:0] KEY_BASE    = 8'hD3,
    localparam int           IDX_W       = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1
) (
    input  logic [TBL_W-1:0]      bus_table,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic                  bus_rd,
    input  level_e                level,
    input  logic [7:0]            mem_rdata,
    input  logic [PW_BYTES*8-1:0] l1_pw,
    output logic                  entry_we,
    output logic                  key_we,
    output logic [IDX_W-1:0]      byte_idx,
    output logic [7:0]            bus_rdata,
    output logic                  mem_we,
    output logic                  mem_re,
    output logic [NUM_RGN-1:0]    rgn_rd_ok,
    output logic [NUM_RGN-1:0]    rgn_wr_ok
);

    logic [ADDR_W:0] ent_off;
    logic [ADDR_W:0] key_off;
    logic            entry_hit;
    logic            key_hit;
    region_e         region;
    logic [7:0]      key_byte;

    assign ent_off = {1'b0, bus_addr} - {1'b0, ENTRY_BASE};
    assign key_off = {1'b0, bus_addr} - {1'b0, KEY_BASE};

    // Range hits for the entry window and the level-1 password window.
    always_comb begin
        entry_hit = (bus_table == ENTRY_TABLE) && (bus_addr >= ENTRY_BASE)
                    && (ent_off < (ADDR_W+1)'(PW_BYTES));
        key_hit   = (bus_table == KEY_TABLE) && (bus_addr >= KEY_BASE)
                    && (key_off < (ADDR_W+1)'(PW_BYTES));
    end

    // Region of the access; the entry window counts as monitor area.
    always_comb begin
        if (key_hit)                       region = RGN_KEY;
        else if (bus_table == ENTRY_TABLE) region = RGN_MON;
        else if (bus_table == CUST_TABLE)  region = RGN_CUST;
        else                               region = RGN_CTRL;
    end

    assign rgn_rd_ok = rd_rights(level);
    assign rgn_wr_ok = wr_rights(level);

    assign byte_idx = entry_hit ? ent_off[IDX_W-1:0] : key_off[IDX_W-1:0];
    assign entry_we = bus_we && entry_hit;
    assign key_we   = bus_we && key_hit && rgn_wr_ok[RGN_KEY];

    // Memory strobes pass only for allowed accesses outside the local windows.
    always_comb begin
        mem_we = bus_we && !entry_hit && !key_hit && rgn_wr_ok[region];
        mem_re = bus_rd && !entry_hit && !key_hit && rgn_rd_ok[region];
    end

    // Select the addressed level-1 password byte, most significant first.
    always_comb begin
        key_byte = 8'h00;
        for (int i = 0; i < PW_BYTES; i++) begin
            if (byte_idx == IDX_W'(i)) key_byte = l1_pw[(PW_BYTES-1-i)*8 +: 8];
        end
    end

    // Masked read data.
    always_comb begin
        if (entry_hit || !rgn_rd_ok[region]) bus_rdata = 8'hFF;
        else if (key_hit)                    bus_rdata = key_byte;
        else                                 bus_rdata = mem_rdata;
    end

endmodule

// File: rtl/pwd_access_ctrl.sv
// Top of the password-gated access controller.
// Holds the write-only entry and the level-1 password, and derives the level.
// Drives the gated memory strobes and the masked read data.
// Assumes one bus access per cycle and a synchronous active-low reset.
module pwd_access_ctrl
    import pwd_pkg::*;
#(
    parameter int            TBL_W       = 8,
    parameter int            ADDR_W      = 8,
    parameter int            PW_BYTES    = 4,
    parameter logic [TBL_W-1:0]  ENTRY_TABLE = 8'h00,
    parameter logic [ADDR_W-1:0] ENTRY_BASE  = 8'h7B,
    parameter logic [TBL_W-1:0]  CUST_TABLE  = 8'h01,
    parameter logic [TBL_W-1:0]  KEY_TABLE   = 8'h03,
    parameter logic [ADDR_W-1:0] KEY_BASE    = 8'hD3,
    parameter logic [PW_BYTES*8-1:0] L1_DEFAULT  = '0,
    parameter logic [PW_BYTES*8-1:0] L2_PASSWORD = '0,
    localparam int           IDX_W       = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TBL_W-1:0]  bus_table,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [1:0]        access_level,
    output logic [3:0]        rgn_rd_ok,
    output logic [3:0]        rgn_wr_ok
);

    logic [PW_BYTES*8-1:0] entry;
    logic [PW_BYTES*8-1:0] l1_pw;
    logic                  entry_we;
    logic                  key_we;
    logic [IDX_W-1:0]      byte_idx;
    level_e                level;

    pwd_byte_reg #(.PW_BYTES(PW_BYTES), .RESET_VAL('1)) u_entry (
        .clk(clk), .rst_n(rst_n), .wr_en(entry_we), .idx(byte_idx),
        .wdata(bus_wdata), .value(entry)
    );

    pwd_byte_reg #(.PW_BYTES(PW_BYTES), .RESET_VAL(L1_DEFAULT)) u_l1_store (
        .clk(clk), .rst_n(rst_n), .wr_en(key_we), .idx(byte_idx),
        .wdata(bus_wdata), .value(l1_pw)
    );

    pwd_compare #(.PW_BYTES(PW_BYTES), .L2_PASSWORD(L2_PASSWORD)) u_cmp (
        .entry(entry), .l1_pw(l1_pw), .level(level)
    );

    pwd_region_decode #(
        .TBL_W(TBL_W), .ADDR_W(ADDR_W), .PW_BYTES(PW_BYTES),
        .ENTRY_TABLE(ENTRY_TABLE), .ENTRY_BASE(ENTRY_BASE),
        .CUST_TABLE(CUST_TABLE), .KEY_TABLE(KEY_TABLE), .KEY_BASE(KEY_BASE)
    ) u_dec (
        .bus_table(bus_table), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_rd(bus_rd), .level(level), .mem_rdata(mem_rdata), .l1_pw(l1_pw),
        .entry_we(entry_we), .key_we(key_we), .byte_idx(byte_idx),
        .bus_rdata(bus_rdata), .mem_we(mem_we), .mem_re(mem_re),
        .rgn_rd_ok(rgn_rd_ok), .rgn_wr_ok(rgn_wr_ok)
    );

    assign access_level = level;

endmodule

// File: rtl/pwd_access_chk.sv
// Checker for pwd_access_ctrl, attached through bind below.
// Observes the ports plus the stored level-1 password.
module pwd_access_chk #(
    parameter int            TBL_W       = 8,
    parameter int            ADDR_W      = 8,
    parameter int            PW_BYTES    = 4,
    parameter logic [TBL_W-1:0]  ENTRY_TABLE = 8'h00,
    parameter logic [ADDR_W-1:0] ENTRY_BASE  = 8'h7B,
    parameter logic [TBL_W-1:0]  CUST_TABLE  = 8'h01,
    parameter logic [TBL_W-1:0]  KEY_TABLE   = 8'h03,
    parameter logic [ADDR_W-1:0] KEY_BASE    = 8'hD3,
    parameter logic [PW_BYTES*8-1:0] L1_DEFAULT  = '0,
    parameter logic [PW_BYTES*8-1:0] L2_PASSWORD = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [TBL_W-1:0]      bus_table,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_we,
    input logic                  bus_rd,
    input logic [7:0]            bus_rdata,
    input logic                  mem_we,
    input logic                  mem_re,
    input logic [1:0]            access_level,
    input logic [3:0]            rgn_wr_ok,
    input logic [PW_BYTES*8-1:0] l1_pw
);

    localparam bit RESET_IS_USER = (L2_PASSWORD != '1) && (L1_DEFAULT != '1);

    logic in_entry;
    logic in_key;
    assign in_entry = (bus_table == ENTRY_TABLE) && (bus_addr >= ENTRY_BASE)
                      && ({1'b0, bus_addr} < {1'b0, ENTRY_BASE} + (ADDR_W+1)'(PW_BYTES));
    assign in_key   = (bus_table == KEY_TABLE) && (bus_addr >= KEY_BASE)
                      && ({1'b0, bus_addr} < {1'b0, KEY_BASE} + (ADDR_W+1)'(PW_BYTES));

    // R1: first cycle out of reset is user level
    a_r1_reset_user: assert property (@(posedge clk)
        (RESET_IS_USER && $rose(rst_n)) |-> access_level == 2'b00);

    // R3: entry bytes never read back and never reach memory
    a_r3_entry_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_entry) |-> (bus_rdata == 8'hFF && !mem_re));

    // R5: code 11 never appears
    a_r5_level_code: assert property (@(posedge clk) disable iff (!rst_n)
        access_level != 2'b11);

    // R6: level moves only after a write
    a_r6_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_we)) |-> $stable(access_level));

    // R7: password store untouched by writes below level 2
    a_r7_key_locked: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_we && in_key) && $past(access_level) != 2'b10)
        |-> l1_pw == $past(l1_pw));

    // R8: no memory write to the customer area at user level
    a_r8_cust_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && bus_table == CUST_TABLE) |-> access_level != 2'b00);

    // R9: user level has no write rights at all
    a_r9_user_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (access_level == 2'b00) |-> rgn_wr_ok == 4'b0000);

endmodule

bind pwd_access_ctrl pwd_access_chk #(
    .TBL_W(TBL_W), .ADDR_W(ADDR_W), .PW_BYTES(PW_BYTES),
    .ENTRY_TABLE(ENTRY_TABLE), .ENTRY_BASE(ENTRY_BASE),
    .CUST_TABLE(CUST_TABLE), .KEY_TABLE(KEY_TABLE), .KEY_BASE(KEY_BASE),
    .L1_DEFAULT(L1_DEFAULT), .L2_PASSWORD(L2_PASSWORD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_table(bus_table), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .mem_we(mem_we),
    .mem_re(mem_re), .access_level(access_level), .rgn_wr_ok(rgn_wr_ok),
    .l1_pw(l1_pw)
);

// File: tb/pwd_access_ctrl_tb.sv
module pwd_access_ctrl_tb;

    localparam logic [31:0] L2PW = 32'h0000_0000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_table = 8'h00;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] mem_rdata;
    logic       mem_we;
    logic       mem_re;
    logic [1:0] access_level;
    logic [3:0] rgn_rd_ok;
    logic [3:0] rgn_wr_ok;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] m_ent;
    logic [31:0] m_l1;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_model(logic [7:0] t, logic [7:0] a);
        return t ^ {a[3:0], a[7:4]} ^ 8'h3C;
    endfunction
    assign mem_rdata = mem_model(bus_table, bus_addr);

    pwd_access_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_table(bus_table), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_re(mem_re), .access_level(access_level), .rgn_rd_ok(rgn_rd_ok),
        .rgn_wr_ok(rgn_wr_ok)
    );

    function automatic logic [1:0] exp_level(logic [31:0] e, logic [31:0] l1);
        if (e == L2PW) return 2'b10;
        if (e == l1)   return 2'b01;
        return 2'b00;
    endfunction

    // 0 mon, 1 cust, 2 ctrl, 3 key, 4 entry
    function automatic int exp_region(logic [7:0] t, logic [7:0] a);
        if (t == 8'h00 && a >= 8'h7B && a <= 8'h7E) return 4;
        if (t == 8'h03 && a >= 8'hD3 && a <= 8'hD6) return 3;
        if (t == 8'h00) return 0;
        if (t == 8'h01) return 1;
        return 2;
    endfunction

    function automatic logic [3:0] exp_rd(logic [1:0] l);
        return (l == 2'b10) ? 4'b1111 : (l == 2'b01) ? 4'b0011 : 4'b0001;
    endfunction

    function automatic logic [3:0] exp_wr(logic [1:0] l);
        return (l == 2'b10) ? 4'b1111 : (l == 2'b01) ? 4'b0011 : 4'b0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_level(input string req);
        logic [1:0] e;
        e = exp_level(m_ent, m_l1);
        chk(access_level == e, req, 32'(access_level), 32'(e));
    endtask

    task automatic chk_rights(input string req);
        logic [1:0] e;
        e = exp_level(m_ent, m_l1);
        chk(rgn_rd_ok == exp_rd(e), req, 32'(rgn_rd_ok), 32'(exp_rd(e)));
        chk(rgn_wr_ok == exp_wr(e), req, 32'(rgn_wr_ok), 32'(exp_wr(e)));
    endtask

    task automatic do_write(input logic [7:0] t, input logic [7:0] a,
                            input logic [7:0] d, input string req);
        int  r;
        logic [1:0] lv;
        logic ew;
        @(negedge clk);
        bus_table = t; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        r  = exp_region(t, a);
        lv = exp_level(m_ent, m_l1);
        ew = (r < 3) && exp_wr(lv)[r];
        #1 chk(mem_we == ew, req, 32'(mem_we), 32'(ew));
        if (r == 4) m_ent[(3 - (int'(a) - 'h7B))*8 +: 8] = d;
        if (r == 3 && lv == 2'b10) m_l1[(3 - (int'(a) - 'hD3))*8 +: 8] = d;
        @(negedge clk);
        bus_we = 1'b0;
        #1 chk_level(req);
    endtask

    task automatic do_read(input logic [7:0] t, input logic [7:0] a, input string req);
        int  r;
        logic [1:0] lv;
        logic [7:0] ed;
        logic er;
        @(negedge clk);
        bus_table = t; bus_addr = a; bus_rd = 1'b1;
        r  = exp_region(t, a);
        lv = exp_level(m_ent, m_l1);
        if (r == 4 || !exp_rd(lv)[r]) ed = 8'hFF;
        else if (r == 3)               ed = m_l1[(3 - (int'(a) - 'hD3))*8 +: 8];
        else                           ed = mem_model(t, a);
        er = (r < 3) && exp_rd(lv)[r];
        #1;
        chk(bus_rdata == ed, req, 32'(bus_rdata), 32'(ed));
        chk(mem_re == er, req, 32'(mem_re), 32'(er));
        @(negedge clk);
        bus_rd = 1'b0;
        #1 chk_level(req);
    endtask

    task automatic put_entry(input logic [31:0] v, input string req);
        for (int i = 0; i < 4; i++) do_write(8'h00, 8'(8'h7B + i), v[(3-i)*8 +: 8], req);
    endtask

    task automatic put_l1(input logic [31:0] v, input string req);
        for (int i = 0; i < 4; i++) do_write(8'h03, 8'(8'hD3 + i), v[(3-i)*8 +: 8], req);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ent = 32'hFFFF_FFFF;
        m_l1  = 32'h0000_0000;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] pick;
        logic [7:0]  t, a;
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        chk_level("R1 reset level");
        chk_rights("R1/R9 reset rights");
        // R3 entry unreadable
        do_read(8'h00, 8'h7B, "R3 entry read");
        do_read(8'h00, 8'h7E, "R3 entry read");
        // R8 customer and control blocked at user
        do_read(8'h01, 8'h20, "R8 cust read at user");
        do_write(8'h01, 8'h20, 8'h55, "R8 cust write at user");
        do_read(8'h05, 8'h10, "R8 ctrl read at user");
        do_read(8'h00, 8'h10, "R9 monitor read at user");
        // R7 password write ignored at user, R11 masked
        do_write(8'h03, 8'hD3, 8'hAA, "R7 key write at user");
        do_read(8'h03, 8'hD3, "R11 key read at user");
        // R2 partial key, R4 both match -> level 2
        do_write(8'h00, 8'h7B, 8'h00, "R2 partial entry");
        do_write(8'h00, 8'h7C, 8'h00, "R2 partial entry");
        do_write(8'h00, 8'h7D, 8'h00, "R2 partial entry");
        do_write(8'h00, 8'h7E, 8'h00, "R4 level2 priority");
        chk_rights("R9 rights at level2");
        do_read(8'h03, 8'hD3, "R11 key read at level2");
        put_l1(32'h1234_5678, "R7 key write at level2");
        do_read(8'h03, 8'hD4, "R11 key byte order");
        do_read(8'h03, 8'hD6, "R11 key byte order");
        do_write(8'h05, 8'h40, 8'h11, "R6 ctrl write keeps level");
        // R5 level 1, with R2 intermediate
        put_entry(32'h1234_5678, "R5 level1 entry");
        chk_rights("R9 rights at level1");
        do_read(8'h01, 8'h33, "R8 cust read at level1");
        do_read(8'h07, 8'h33, "R8 ctrl read at level1");
        do_write(8'h00, 8'h10, 8'h99, "R9 monitor write at level1");
        do_write(8'h03, 8'hD3, 8'hAA, "R7 key write at level1");
        do_read(8'h03, 8'hD3, "R11 key read at level1");
        // R6 change entry drops level
        do_write(8'h00, 8'h7E, 8'h00, "R6 entry change drops");
        // R10 all-ones password with all-ones entry
        put_entry(32'h0000_0000, "R4 back to level2");
        do_read(8'h03, 8'hD3, "R7 ignored write left key");
        put_l1(32'hFFFF_FFFF, "R10 set all ones");
        put_entry(32'hFFFF_FFFF, "R10 all ones entry");
        // R1 reset restores
        do_reset();
        chk_level("R1 level after second reset");
        // random mix
        for (int n = 0; n < 600; n++) begin
            case ($urandom % 5)
                0, 1: begin
                    case ($urandom % 4)
                        0: pick = L2PW;
                        1: pick = m_l1;
                        2: pick = 32'hFFFF_FFFF;
                        default: pick = $urandom;
                    endcase
                    a = 8'(8'h7B + ($urandom % 4));
                    do_write(8'h00, a, pick[(3 - (int'(a) - 'h7B))*8 +: 8], "R2 random entry");
                end
                2: begin
                    a = 8'(8'hD3 + ($urandom % 4));
                    do_write(8'h03, a, 8'($urandom % 3 == 0 ? 0 : $urandom), "R7 random key write");
                end
                3: begin
                    t = 8'($urandom % 6);
                    a = ($urandom % 2 == 0) ? 8'(8'h78 + ($urandom % 8)) : 8'(8'hD0 + ($urandom % 8));
                    do_read(t, a, "R8 random read");
                end
                default: begin
                    t = 8'($urandom % 6);
                    a = 8'($urandom);
                    if (exp_region(t, a) >= 3) a = 8'h00;
                    do_write(t, a, 8'($urandom), "R6 random other write");
                    chk_rights("R9 random rights");
                end
            endcase
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule